// File: doc/BRIEF.md
# Power Domain Switch Controller

This block switches up to eight power domains on and off for software over a simple 32-bit register bus. Software places a domain mask in a power-up request register or a power-down request register. That write alone changes nothing. The request is committed only when software writes a three-value key into a single trigger register. The key for power-up differs from the key for power-down.

A sequencer accepts the committed request and waits a settle time set at build time. It then updates a live power-state register for every domain in the latched mask. Software polls that register to see when the change is complete. A nine-bit interrupt status unit records three kinds of event: completion, wrong key use and events from stub hardware inputs. Each status bit can be masked away from the interrupt output. A per-domain event register records which domains changed state.

Key tracker states: `K_IDLE` (waiting for the arm value), `K_ARMED` (arm value seen), `K_ON_WAIT` (power-up second value seen), `K_OFF_WAIT` (power-down second value seen). Its transitions are: arm (`K_IDLE`→`K_ARMED`), pick-up (`K_ARMED`→`K_ON_WAIT`), pick-down (`K_ARMED`→`K_OFF_WAIT`), commit or reject (`K_ON_WAIT`/`K_OFF_WAIT`→`K_IDLE`), and break (any state→`K_IDLE` on a wrong value). Sequencer states: `S_IDLE`, `S_SETTLE` (counting down) and `S_APPLY` (one cycle, updates the power state). Its transitions are: start (`S_IDLE`→`S_SETTLE`), expire (`S_SETTLE`→`S_APPLY`) and finish (`S_APPLY`→`S_IDLE`).

Top module: `pwr_dom_ctrl`

## Requirements
- R1: After reset the power-state register (0x80) reads 0x03 (domains 0 and 1 powered). The interrupt mask (0x48) reads 0x1FF. The interrupt status (0x8C), the event register (0x88) and both request registers (0x0C up, 0x10 down) read 0. `irq` is 0.
- R2: A write to the request registers is stored and reads back (low 8 bits). It leaves the power state unchanged.
- R3: Writing 0xFF, 0x05, 0x50 on three successive writes to 0x44 powers up every domain set in 0x0C. The power-state register keeps its old value for SETTLE_CYCLES clock edges after the edge that accepts the final key write. It shows the new value on edge SETTLE_CYCLES+1 (17 by default).
- R4: Writing 0xFF, 0x0A, 0xA0 to 0x44 powers down every domain set in 0x10, with the same timing as R3.
- R5: A key write that breaks the expected order returns the tracker to idle and changes no domain. It sets status bit 3 when the tracker had seen 0xFF then 0x0A. In every other case it sets status bit 2. A later correct sequence still works.
- R6: When a transition completes, status bit 0 is set. Bit n of the event register (0x88) is set for each domain n whose state changed.
- R7: A complete, correct key sequence that ends while a transition is still settling is rejected. It sets bit 2 (power-up key) or bit 3 (power-down key) and leaves the running transition unaffected.
- R8: Writing 1s to 0x8C clears those status bits. Writing 1s to 0x88 clears those event bits. Bits written as 0 are kept.
- R9: `irq` is 1 exactly when some status bit is 1 and its mask bit (0x48, 1 = suppress) is 0.
- R10: The stub inputs set status bits directly. `hw_req_stub` sets bit 1, `hw_fail_stub[1:0]` sets bits 5:4 and `pch_fail_stub[2:0]` sets bits 8:6.
- R11: The domain mask is captured when the key sequence completes. A change to the request register during the settle time does not change the domains that are switched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |
| hw_req_stub | input | 1 | Stub hardware request event |
| hw_fail_stub | input | 2 | Stub hardware-trigger failure events |
| pch_fail_stub | input | 3 | Stub handshake failure events |

## Verification
The main function is swept over all 256 power-up masks, each applied from the all-off state. This separates domains that are switched from domains that are left alone, and checks that the event register tracks exactly the changed bits. Each power-up is followed by a partial power-down with a derived mask. That step tells set bits apart from cleared bits within one state word. Directed patterns cover the rest: the cycle of the state change, broken key orders in each tracker state, a second key sequence during settling, and a mask changed during settling. These separate a key tracker that commits too early, a sequencer that reads the live mask, and failure bits that land on the wrong position.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    localparam logic [7:0] OFS_ON_REQ   = 8'h0C;
    localparam logic [7:0] OFS_OFF_REQ  = 8'h10;
    localparam logic [7:0] OFS_KEY      = 8'h44;
    localparam logic [7:0] OFS_INT_MASK = 8'h48;
    localparam logic [7:0] OFS_PWR      = 8'h80;
    localparam logic [7:0] OFS_EVT      = 8'h88;
    localparam logic [7:0] OFS_INT_ST   = 8'h8C;

    localparam logic [31:0] KEY_ARM   = 32'h0000_00FF;
    localparam logic [31:0] KEY_ON_A  = 32'h0000_0005;
    localparam logic [31:0] KEY_ON_B  = 32'h0000_0050;
    localparam logic [31:0] KEY_OFF_A = 32'h0000_000A;
    localparam logic [31:0] KEY_OFF_B = 32'h0000_00A0;

    localparam int INT_W = 9;

    typedef enum logic [1:0] {K_IDLE, K_ARMED, K_ON_WAIT, K_OFF_WAIT} key_state_t;
    typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_APPLY} seq_state_t;
endpackage

// File: rtl/pdc_key_fsm.sv
module pdc_key_fsm
    import pdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_val,
    input  logic        busy,
    output logic        go_on,
    output logic        go_off,
    output logic        err_on,
    output logic        err_off
);
    key_state_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= K_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt  = st;
        go_on   = 1'b0;
        go_off  = 1'b0;
        err_on  = 1'b0;
        err_off = 1'b0;
        if (key_wr) begin
            unique case (st)
                K_IDLE: begin
                    if (key_val == KEY_ARM) st_nxt = K_ARMED;
                    else                    err_on = 1'b1;
                end
                K_ARMED: begin
                    if (key_val == KEY_ON_A)       st_nxt = K_ON_WAIT;
                    else if (key_val == KEY_OFF_A) st_nxt = K_OFF_WAIT;
                    else begin
                        st_nxt = K_IDLE;
                        err_on = 1'b1;
                    end
                end
                K_ON_WAIT: begin
                    st_nxt = K_IDLE;
                    if (key_val == KEY_ON_B && !busy) go_on  = 1'b1;
                    else                              err_on = 1'b1;
                end
                K_OFF_WAIT: begin
                    st_nxt = K_IDLE;
                    if (key_val == KEY_OFF_B && !busy) go_off  = 1'b1;
                    else                               err_off = 1'b1;
                end
            endcase
        end
    end

    // R5: a write yields at most one outcome
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_on, go_off, err_on, err_off}));

    // R5: any failure leaves the tracker idle
    a_r5_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (err_on || err_off) |=> st == K_IDLE);
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
    import pdc_pkg::*;
#(
    parameter int              NDOM          = 8,
    parameter int              SETTLE_CYCLES = 16,
    parameter logic [NDOM-1:0] RESET_PWR     = NDOM'(3)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_on,
    input  logic            go_off,
    input  logic [NDOM-1:0] on_mask,
    input  logic [NDOM-1:0] off_mask,
    input  logic [NDOM-1:0] evt_clr,
    output logic            busy,
    output logic            done,
    output logic [NDOM-1:0] pwr,
    output logic [NDOM-1:0] evt
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYCLES - 1);

    seq_state_t      st, st_nxt;
    logic [CW-1:0]   cnt, cnt_nxt;
    logic            dir_on;
    logic [NDOM-1:0] mask_q;
    logic [NDOM-1:0] pwr_q, pwr_nxt, evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cnt    <= '0;
            dir_on <= 1'b0;
            mask_q <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            if (st == S_IDLE && (go_on || go_off)) begin
                dir_on <= go_on;
                mask_q <= go_on ? on_mask : off_mask;
            end
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            S_IDLE: begin
                if (go_on || go_off) begin
                    st_nxt  = S_SETTLE;
                    cnt_nxt = CNT_LOAD;
                end
            end
            S_SETTLE: begin
                if (cnt == '0) st_nxt = S_APPLY;
                else           cnt_nxt = cnt - 1'b1;
            end
            S_APPLY: st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    always_comb begin
        pwr_nxt = dir_on ? (pwr_q | mask_q) : (pwr_q & ~mask_q);
        busy    = (st != S_IDLE);
        done    = (st == S_APPLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= RESET_PWR;
            evt_q <= '0;
        end else begin
            if (st == S_APPLY) pwr_q <= pwr_nxt;
            evt_q <= (evt_q & ~evt_clr) | ((st == S_APPLY) ? (pwr_q ^ pwr_nxt) : '0);
        end
    end

    assign pwr = pwr_q;
    assign evt = evt_q;

    // R3: power state moves only in the apply state
    a_r3_hold_until_apply: assert property (@(posedge clk) disable iff (!rst_n)
        st != S_APPLY |=> $stable(pwr_q));

    // R7: the key tracker never starts a busy sequencer
    a_r7_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (go_on || go_off) |-> st == S_IDLE);

    // R3: settle counter stays in range
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_SETTLE |-> cnt < CW'(SETTLE_CYCLES));

    // R11: latched mask is frozen while settling
    a_r11_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_SETTLE |=> $stable(mask_q));
endmodule

// File: rtl/pdc_irq.sv
module pdc_irq
    import pdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] set_v,
    input  logic [INT_W-1:0] clr_v,
    input  logic             mask_wr,
    input  logic [INT_W-1:0] mask_val,
    output logic [INT_W-1:0] st,
    output logic [INT_W-1:0] mask,
    output logic             irq
);
    logic [INT_W-1:0] st_q, mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            mask_q <= '1;
        end else begin
            st_q <= (st_q & ~clr_v) | set_v;
            if (mask_wr) mask_q <= mask_val;
        end
    end

    assign st   = st_q;
    assign mask = mask_q;
    assign irq  = |(st_q & ~mask_q);

    // R8: cleared bits are gone next cycle when nothing sets them
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v == '0) |=> ((st_q & $past(clr_v)) == '0));

    // R10: a set event is always recorded
    a_r10_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((st_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl
    import pdc_pkg::*;
#(
    parameter int NDOM          = 8,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        hw_req_stub,
    input  logic [1:0]  hw_fail_stub,
    input  logic [2:0]  pch_fail_stub
);
    logic [NDOM-1:0]  on_req, off_req, pwr, evt, evt_clr;
    logic             go_on, go_off, err_on, err_off, busy, done;
    logic [INT_W-1:0] int_set, int_clr, int_st, int_mask;
    logic             wr_key, wr_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_req  <= '0;
            off_req <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_ON_REQ)  on_req  <= bus_wdata[NDOM-1:0];
            if (bus_addr == OFS_OFF_REQ) off_req <= bus_wdata[NDOM-1:0];
        end
    end

    assign wr_key  = bus_wr && (bus_addr == OFS_KEY);
    assign wr_mask = bus_wr && (bus_addr == OFS_INT_MASK);
    assign evt_clr = (bus_wr && bus_addr == OFS_EVT) ? bus_wdata[NDOM-1:0] : '0;
    assign int_clr = (bus_wr && bus_addr == OFS_INT_ST) ? bus_wdata[INT_W-1:0] : '0;
    assign int_set = {pch_fail_stub, hw_fail_stub, err_off, err_on, hw_req_stub, done};

    pdc_key_fsm u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_val(bus_wdata), .busy(busy),
        .go_on(go_on), .go_off(go_off), .err_on(err_on), .err_off(err_off)
    );

    pdc_seq #(.NDOM(NDOM), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_on(go_on), .go_off(go_off),
        .on_mask(on_req), .off_mask(off_req), .evt_clr(evt_clr),
        .busy(busy), .done(done), .pwr(pwr), .evt(evt)
    );

    pdc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_v(int_set), .clr_v(int_clr),
        .mask_wr(wr_mask), .mask_val(bus_wdata[INT_W-1:0]),
        .st(int_st), .mask(int_mask), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_ON_REQ:   bus_rdata[NDOM-1:0]  = on_req;
            OFS_OFF_REQ:  bus_rdata[NDOM-1:0]  = off_req;
            OFS_INT_MASK: bus_rdata[INT_W-1:0] = int_mask;
            OFS_PWR:      bus_rdata[NDOM-1:0]  = pwr;
            OFS_EVT:      bus_rdata[NDOM-1:0]  = evt;
            OFS_INT_ST:   bus_rdata[INT_W-1:0] = int_st;
            default:      bus_rdata = '0;
        endcase
    end

    // R6: completion raises the done status bit
    a_r6_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> int_st[0]);
endmodule

// File: tb/tb_pwr_dom_ctrl.sv
module tb_pwr_dom_ctrl;
    localparam int SETTLE = 16;
    localparam logic [7:0] A_ON = 8'h0C, A_OFF = 8'h10, A_KEY = 8'h44, A_MSK = 8'h48,
                           A_PWR = 8'h80, A_EVT = 8'h88, A_INT = 8'h8C;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0, bus_rdata;
    logic        irq, hw_req_stub = 1'b0;
    logic [1:0]  hw_fail_stub = 2'b0;
    logic [2:0]  pch_fail_stub = 3'b0;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [7:0] model;

    pwr_dom_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .hw_req_stub(hw_req_stub), .hw_fail_stub(hw_fail_stub), .pch_fail_stub(pch_fail_stub)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic keys(input bit up);
        wr(A_KEY, 32'hFF);
        wr(A_KEY, up ? 32'h05 : 32'h0A);
        wr(A_KEY, up ? 32'h50 : 32'hA0);
    endtask

    task automatic settle();
        repeat (SETTLE + 1) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_PWR, v); chk("R1 pwr", v, 32'h03);
        rd(A_MSK, v); chk("R1 mask", v, 32'h1FF);
        rd(A_INT, v); chk("R1 int", v, 32'h0);
        rd(A_EVT, v); chk("R1 evt", v, 32'h0);
        rd(A_ON, v);  chk("R1 onreq", v, 32'h0);
        rd(A_OFF, v); chk("R1 offreq", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        model = 8'h03;

        // R2 requests alone do nothing
        wr(A_ON, 32'hFFFF_FFFF);
        wr(A_OFF, 32'h0000_01A5);
        repeat (SETTLE + 4) @(negedge clk);
        rd(A_ON, v);  chk("R2 onreq readback", v, 32'hFF);
        rd(A_OFF, v); chk("R2 offreq readback", v, 32'hA5);
        rd(A_PWR, v); chk("R2 pwr unchanged", v, 32'h03);

        // R3 exact timing
        wr(A_ON, 32'h10);
        keys(1'b1);
        repeat (SETTLE) @(negedge clk);
        rd(A_PWR, v); chk("R3 before edge", v, 32'h03);
        @(negedge clk);
        rd(A_PWR, v); chk("R3 at edge", v, 32'h13);
        model = 8'h13;
        rd(A_INT, v); chk("R6 done bit", v, 32'h1);
        rd(A_EVT, v); chk("R6 evt", v, 32'h10);
        wr(A_INT, 32'h1FF); wr(A_EVT, 32'hFF);

        // R5 broken orders
        wr(A_KEY, 32'h05);
        rd(A_INT, v); chk("R5 idle non-arm", v, 32'h004);
        wr(A_INT, 32'h1FF);
        wr(A_KEY, 32'hFF); wr(A_KEY, 32'h33);
        rd(A_INT, v); chk("R5 armed wrong", v, 32'h004);
        wr(A_INT, 32'h1FF);
        wr(A_KEY, 32'hFF); wr(A_KEY, 32'h0A); wr(A_KEY, 32'h50);
        rd(A_INT, v); chk("R5 down branch wrong", v, 32'h008);
        wr(A_INT, 32'h1FF);
        wr(A_KEY, 32'hFF); wr(A_KEY, 32'h05); wr(A_KEY, 32'hFF);
        rd(A_INT, v); chk("R5 up branch wrong", v, 32'h004);
        wr(A_INT, 32'h1FF);
        repeat (SETTLE + 2) @(negedge clk);
        rd(A_PWR, v); chk("R5 no state change", v, {24'h0, model});

        // R7 second sequence while settling
        wr(A_OFF, 32'h01);
        wr(A_ON, 32'h80);
        keys(1'b1);
        keys(1'b0);
        rd(A_INT, v); chk("R7 reject flag", v, 32'h008);
        repeat (SETTLE - 2) @(negedge clk);
        model = model | 8'h80;
        rd(A_PWR, v); chk("R7 only first applied", v, {24'h0, model});
        rd(A_INT, v); chk("R7 done after reject", v, 32'h009);
        wr(A_INT, 32'h1FF); wr(A_EVT, 32'hFF);

        // R11 mask latched at commit
        wr(A_ON, 32'h20);
        keys(1'b1);
        wr(A_ON, 32'h40);
        repeat (SETTLE) @(negedge clk);
        model = model | 8'h20;
        rd(A_PWR, v); chk("R11 latched mask", v, {24'h0, model});

        // R9 masking
        rd(A_INT, v); chk("R9 done set", v, 32'h1);
        chk("R9 masked irq", {31'h0, irq}, 32'h0);
        wr(A_MSK, 32'h1FE);
        #1; chk("R9 unmasked irq", {31'h0, irq}, 32'h1);
        wr(A_INT, 32'h1);
        #1; chk("R9 irq after clear", {31'h0, irq}, 32'h0);
        wr(A_MSK, 32'h1FF);

        // R10 stub events
        @(negedge clk);
        hw_req_stub = 1'b1; hw_fail_stub = 2'b10; pch_fail_stub = 3'b100;
        @(negedge clk);
        hw_req_stub = 1'b0; hw_fail_stub = 2'b00; pch_fail_stub = 3'b000;
        rd(A_INT, v); chk("R10 stub bits", v, 32'h122);

        // R8 partial clears
        wr(A_INT, 32'h020);
        rd(A_INT, v); chk("R8 int partial", v, 32'h102);
        wr(A_INT, 32'h1FF);
        rd(A_EVT, v); chk("R8 evt before", v, 32'h20);
        wr(A_EVT, 32'h01);
        rd(A_EVT, v); chk("R8 evt keep", v, 32'h20);
        wr(A_EVT, 32'h20);
        rd(A_EVT, v); chk("R8 evt cleared", v, 32'h0);

        // R4 / R6 sweep over all masks
        for (int m = 0; m < 256; m++) begin
            logic [7:0] prev, dm;
            prev = model;
            wr(A_OFF, 32'hFF);
            keys(1'b0); settle();
            model = 8'h00;
            rd(A_PWR, v); chk("R4 all down", v, 32'h0);
            rd(A_EVT, v); chk("R6 evt down", v, {24'h0, prev});
            wr(A_EVT, 32'hFF); wr(A_INT, 32'h1FF);
            wr(A_ON, 32'(m));
            keys(1'b1); settle();
            model = 8'(m);
            rd(A_PWR, v); chk("R3 sweep up", v, {24'h0, model});
            rd(A_EVT, v); chk("R6 evt up", v, {24'h0, model});
            wr(A_EVT, 32'hFF);
            dm = 8'(m) ^ 8'h5A;
            wr(A_OFF, {24'h0, dm});
            keys(1'b0); settle();
            prev = model;
            model = model & ~dm;
            rd(A_PWR, v); chk("R4 partial down", v, {24'h0, model});
            rd(A_EVT, v); chk("R6 evt partial", v, {24'h0, prev ^ model});
            rd(A_INT, v); chk("R6 done sweep", v, 32'h1);
            wr(A_EVT, 32'hFF); wr(A_INT, 32'h1FF);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule